// File: doc/BRIEF.md
# Initialization Handshake Sequence Detector

This block sits behind a master reset and waits for a separate detection unit to ask for initialization. The detection unit drives two single-bit lines. The block combines them into a 2-bit code and follows how that code changes over time. The request is a repeating four-code cycle. Once the cycle has been seen a set number of times in a row without a wrong code, the block answers. It toggles its acknowledge pin a fixed number of times at a fixed spacing. After the last toggle it raises a sticky init-complete flag. Later logic, such as the watchdog and the failure response, starts once that flag is high.

Both lines are asynchronous to the block clock, so each passes through a flop synchronizer before any decision is made. Only a change of the synchronized code counts as an event, so a code held for many cycles is seen once. Every pin is a plain control or status level. No data moves through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `init_handshake_det`

## Requirements
- R1: After reset is asserted (rst_n low), ack_pin and init_done are 0 and the block is listening. It is at the start of the cycle with a repeat count of zero.
- R2: The code is {det_hi, det_lo}, and each line is synchronized through SYNC_STAGES (default 2) flops. Only a change of the synchronized code is acted on, at most one per clock. A change present before clock edge e is acted on at edge e+SYNC_STAGES.
- R3: From the start, code 01 begins a cycle. After that, the expected order is 11, then 10, then 00, then 01 again. Each change to the expected code moves the tracker one step on.
- R4: A change to any code other than the expected one returns the tracker to the start and clears the repeat count to zero. At the start, any change to a code other than 01 leaves the tracker at the start.
- R5: A change from 00 back to 01 completes one cycle and adds one to the repeat count. When the count reaches REPEATS (default 5), the block locks and begins the acknowledge.
- R6: The acknowledge toggles ack_pin TOGGLES times (default 10). The first toggle comes one clock after the lock, and later toggles follow every HOLD_CYCLES clocks. ack_pin ends at 0 and stays there.
- R7: init_done rises one clock after the last toggle and stays high until reset.
- R8: While the acknowledge is running and after it has finished, changes on det_hi and det_lo have no effect on ack_pin or init_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low master reset |
| det_hi | input | 1 | Upper bit of the request code from the detection unit |
| det_lo | input | 1 | Lower bit of the request code from the detection unit |
| ack_pin | output | 1 | Acknowledge pin, toggled as a pulse train |
| init_done | output | 1 | Sticky flag that initialization is complete |

## Verification
The inputs change just after a falling edge. A code present before rising edge e reaches the tracker's decision at edge e+2, because it first crosses the two synchronizer flops. The last 01 of the final cycle therefore locks the tracker at e+2. The first toggle of ack_pin follows at e+3, and each later toggle follows HOLD_CYCLES edges after the one before. init_done appears one edge after the tenth toggle.

The bench model keeps a short queue of past input codes and applies exactly this delay. It predicts both outputs for each edge, and the bench compares them with the design at the next falling edge. A dedicated check also counts the three quiet samples and then the first toggle after the final code.

// File: rtl/ihs_pkg.sv
package ihs_pkg;

  typedef logic [1:0] code_t;

  // tracker position: which code was seen last in the current cycle
  typedef enum logic [2:0] {
    TRK_START,
    TRK_SAW01,
    TRK_SAW11,
    TRK_SAW10,
    TRK_SAW00,
    TRK_LOCK
  } trk_e;

  localparam code_t CODE_OPEN  = 2'b01;
  localparam code_t CODE_SECND = 2'b11;
  localparam code_t CODE_THIRD = 2'b10;
  localparam code_t CODE_FOURT = 2'b00;

  // code that moves the tracker forward from a given position
  function automatic code_t wanted_code(trk_e pos);
    case (pos)
      TRK_SAW01: wanted_code = CODE_SECND;
      TRK_SAW11: wanted_code = CODE_THIRD;
      TRK_SAW10: wanted_code = CODE_FOURT;
      default:   wanted_code = CODE_OPEN;
    endcase
  endfunction

  function automatic trk_e step_after(trk_e pos);
    case (pos)
      TRK_START: step_after = TRK_SAW01;
      TRK_SAW01: step_after = TRK_SAW11;
      TRK_SAW11: step_after = TRK_SAW10;
      TRK_SAW10: step_after = TRK_SAW00;
      default:   step_after = TRK_SAW01;
    endcase
  endfunction

endpackage

// File: rtl/ihs_in_sync.sv
module ihs_in_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] sync_out,
  output logic             changed
);

  logic [WIDTH-1:0] last_q;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    if (STAGES <= 1) begin : g_single
      logic flop_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flop_q <= 1'b0;
        else        flop_q <= raw_in[b];
      end
      assign sync_out[b] = flop_q;
    end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], raw_in[b]};
      end
      assign sync_out[b] = chain_q[STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= '0;
    else        last_q <= sync_out;
  end

  assign changed = (sync_out != last_q);

endmodule

// File: rtl/ihs_seq_track.sv
module ihs_seq_track
  import ihs_pkg::*;
#(
  parameter int REPEATS = 5,
  parameter int CW      = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  code_t         code,
  input  logic          changed,
  output logic [CW-1:0] rep_cnt,
  output logic          seq_ok
);

  localparam logic [CW-1:0] LAST_REP = CW'(REPEATS - 1);
  localparam logic [CW-1:0] FULL_REP = CW'(REPEATS);

  trk_e pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q   <= TRK_START;
      rep_cnt <= '0;
      seq_ok  <= 1'b0;
    end else if (changed && pos_q != TRK_LOCK) begin
      if (code == wanted_code(pos_q)) begin
        if (pos_q == TRK_SAW00) begin
          if (rep_cnt == LAST_REP) begin
            pos_q   <= TRK_LOCK;
            rep_cnt <= FULL_REP;
            seq_ok  <= 1'b1;
          end else begin
            pos_q   <= TRK_SAW01;
            rep_cnt <= rep_cnt + 1'b1;
          end
        end else begin
          pos_q <= step_after(pos_q);
        end
      end else begin
        pos_q   <= TRK_START;
        rep_cnt <= '0;
      end
    end
  end

endmodule

// File: rtl/ihs_ack_train.sv
module ihs_ack_train #(
  parameter int TOGGLES = 10,
  parameter int HOLD    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic ack_pin,
  output logic done
);

  localparam int TW = $clog2(TOGGLES + 1);
  localparam int HW = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic [TW-1:0] LAST_TOG = TW'(TOGGLES);
  localparam logic [HW-1:0] LAST_HLD = HW'(HOLD - 1);

  logic          busy_q;
  logic [TW-1:0] tog_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      tog_q   <= '0;
      hold_q  <= '0;
      ack_pin <= 1'b0;
      done    <= 1'b0;
    end else if (!busy_q) begin
      if (start && !done) begin
        busy_q  <= 1'b1;
        ack_pin <= ~ack_pin;
        tog_q   <= TW'(1);
        hold_q  <= '0;
      end
    end else if (tog_q == LAST_TOG) begin
      busy_q <= 1'b0;
      done   <= 1'b1;
    end else if (hold_q == LAST_HLD) begin
      ack_pin <= ~ack_pin;
      tog_q   <= tog_q + 1'b1;
      hold_q  <= '0;
    end else begin
      hold_q <= hold_q + 1'b1;
    end
  end

endmodule

// File: rtl/init_handshake_det.sv
module init_handshake_det
  import ihs_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int REPEATS     = 5,
  parameter int TOGGLES     = 10,
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic det_hi,
  input  logic det_lo,
  output logic ack_pin,
  output logic init_done
);

  localparam int CNT_W = $clog2(REPEATS + 1);

  code_t            code_s;
  logic             code_chg;
  logic [CNT_W-1:0] rep_cnt;
  logic             seq_ok;

  ihs_in_sync #(
    .STAGES(SYNC_STAGES),
    .WIDTH (2)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .raw_in  ({det_hi, det_lo}),
    .sync_out(code_s),
    .changed (code_chg)
  );

  ihs_seq_track #(
    .REPEATS(REPEATS),
    .CW     (CNT_W)
  ) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .code   (code_s),
    .changed(code_chg),
    .rep_cnt(rep_cnt),
    .seq_ok (seq_ok)
  );

  ihs_ack_train #(
    .TOGGLES(TOGGLES),
    .HOLD   (HOLD_CYCLES)
  ) u_ack (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (seq_ok),
    .ack_pin(ack_pin),
    .done   (init_done)
  );

endmodule

// File: rtl/ihs_checker.sv
module ihs_checker #(
  parameter int REPEATS = 5,
  parameter int CW      = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          seq_ok,
  input logic [CW-1:0] rep_cnt,
  input logic          ack_pin,
  input logic          init_done
);

  // nothing leaves the acknowledge train before the tracker has locked
  assert_quiet_before_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_ok |-> (!ack_pin && !init_done));

  // the flag never drops once raised
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // pin rests low and still once the train has finished
  assert_pin_rest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (!ack_pin && $stable(ack_pin)));

  // the repeat count never passes its target
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rep_cnt) <= REPEATS);

  // lock follows a count one short of the target
  assert_lock_from_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_ok) |-> (int'($past(rep_cnt)) == REPEATS - 1));

  // lock holds whatever the inputs do
  assert_lock_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    seq_ok |=> (seq_ok && int'(rep_cnt) == REPEATS));

endmodule

bind init_handshake_det ihs_checker #(
  .REPEATS(REPEATS),
  .CW     (CNT_W)
) u_ihs_chk (.*);

// File: tb/tb_init_handshake_det.sv
module tb_init_handshake_det;

  localparam int REP  = 5;
  localparam int TOG  = 10;
  localparam int HOLD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic det_hi = 1'b0;
  logic det_lo = 1'b0;
  logic ack_pin, init_done;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  init_handshake_det #(
    .SYNC_STAGES(2),
    .REPEATS    (REP),
    .TOGGLES    (TOG),
    .HOLD_CYCLES(HOLD)
  ) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .det_hi   (det_hi),
    .det_lo   (det_lo),
    .ack_pin  (ack_pin),
    .init_done(init_done)
  );

  // ---------------- behavioural reference ----------------
  int hist[$];
  int m_last;     // last accepted code in the cycle, -1 at the start
  int m_cnt;
  bit m_lock;
  int m_lock_at;
  int edge_no;
  bit exp_pin, exp_done;

  function automatic int succ(int c);
    case (c)
      1: succ = 3;
      3: succ = 2;
      2: succ = 0;
      default: succ = 1;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      m_last = -1; m_cnt = 0; m_lock = 0; m_lock_at = 0; edge_no = 0;
      exp_pin = 0; exp_done = 0;
    end else begin
      int nw, od, t, tg;
      edge_no++;
      hist.push_back({det_hi, det_lo});
      if (hist.size() > 8) void'(hist.pop_front());
      nw = hist[hist.size()-3];
      od = hist[hist.size()-4];
      if (!m_lock && nw != od) begin
        if (m_last == -1) begin
          if (nw == 1) m_last = 1;
        end else if (nw == succ(m_last)) begin
          if (nw == 1) begin
            m_cnt++;
            if (m_cnt == REP) begin m_lock = 1; m_lock_at = edge_no; end
          end
          m_last = nw;
        end else begin
          m_last = -1; m_cnt = 0;
        end
      end
      if (m_lock) begin
        t  = edge_no - m_lock_at;
        tg = (t >= 1) ? (t - 1) / HOLD + 1 : 0;
        if (tg > TOG) tg = TOG;
        exp_pin  = tg[0];
        exp_done = (t >= 2 + (TOG - 1) * HOLD);
      end
    end
  end

  // every-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (ack_pin !== exp_pin) begin
        n_bad++;
        $display("FAIL R6 ack_pin at edge %0d: actual %0b expected %0b", edge_no, ack_pin, exp_pin);
      end
      n_chk++;
      if (init_done !== exp_done) begin
        n_bad++;
        $display("FAIL R7 init_done at edge %0d: actual %0b expected %0b", edge_no, init_done, exp_done);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input int code, input int hold);
    @(negedge clk);
    {det_hi, det_lo} = 2'(code);
    repeat (hold - 1) @(negedge clk);
  endtask

  // from a position where 01 was last seen, run one full cycle
  task automatic one_cycle(input int hold);
    put(3, hold); put(2, hold); put(0, hold); put(1, hold);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    check(ack_pin == 0 && init_done == 0, "R1 outputs in reset", {ack_pin, init_done}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(ack_pin == 0 && init_done == 0, "R1 outputs after reset", {ack_pin, init_done}, 0);

    // R4: non-01 codes from the start do nothing
    put(2, 3); put(0, 3); put(3, 3); put(2, 2); put(0, 3);
    // R3: two good cycles, then a wrong code in the middle
    put(1, 3); one_cycle(3); one_cycle(2);
    put(3, 3); put(0, 3);
    // R4: four more cycles; a count that was not cleared would lock here
    put(1, 3); one_cycle(2); one_cycle(3); one_cycle(2); one_cycle(4);
    repeat (10) @(negedge clk);
    check(ack_pin == 0 && init_done == 0, "R4 wrong code clears count", {ack_pin, init_done}, 0);

    // R4: a 01 out of place breaks the cycle
    put(3, 2); put(1, 2); put(0, 2);
    // R3/R5: fresh run of five cycles with mixed holds
    put(1, 2); one_cycle(2); one_cycle(5); one_cycle(1); one_cycle(3);
    put(3, 2); put(2, 2); put(0, 2);
    // R2: final 01; pin quiet for three samples, toggles on the fourth
    @(negedge clk);
    {det_hi, det_lo} = 2'b01;
    for (int k = 1; k <= 4; k++) begin
      @(negedge clk);
      if (k < 4) check(ack_pin == 0, "R2 no toggle before sync delay", ack_pin, 0);
      else       check(ack_pin == 1, "R2 R5 first toggle after lock", ack_pin, 1);
    end

    // R8: inputs keep changing while the train runs
    for (int k = 0; k < 30; k++) put((k * 7 + 3) % 4, 1);
    repeat (TOG * HOLD) @(negedge clk);
    check(init_done == 1, "R7 init_done raised", init_done, 1);
    check(ack_pin == 0, "R6 pin ends low", ack_pin, 0);
    // R8: more activity after completion
    put(1, 1); one_cycle(1); one_cycle(1); put(2, 3);
    repeat (8) @(negedge clk);
    check(init_done == 1 && ack_pin == 0, "R8 R7 ignored after done", {init_done, ack_pin}, 2);

    // R1: reset mid-life, then a fast run with a change every clock
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    check(ack_pin == 0 && init_done == 0, "R1 cleared by reset", {ack_pin, init_done}, 0);
    {det_hi, det_lo} = 2'b00;
    @(negedge clk); rst_n = 1'b1;
    put(1, 1);
    for (int k = 0; k < REP; k++) one_cycle(1);
    repeat (TOG * HOLD + 6) @(negedge clk);
    check(init_done == 1 && ack_pin == 0, "R2 R7 fast sequence completes", {init_done, ack_pin}, 2);
    finish_run();
  end

endmodule